// File: doc/BRIEF.md
# Bit-Serial Shift-Add Multiplier

This block forms the unsigned product of two operands over a fixed number of clock cycles, using a single adder instead of a full array multiplier. The multiplicand is captured in parallel when an operation begins. The multiplier goes into a shift register and is used one bit per cycle, most significant bit first. On every step the running sum is doubled by a left shift. The multiplicand is then added in only on cycles where the bit currently leaving the top of the shift register is 1.

A client presents both operands with a one-cycle `start` strobe while the block is idle. `busy` stays high for the whole computation. `done` pulses once when the product is final, and `product` and `overflow` then hold until the next accepted start. The result width is a parameter, `RES_W`, which defaults to twice the operand width. A narrower result keeps the low bits of the true product, and `overflow` reports that high bits were lost.

Top module: `serial_mult`

## Requirements
- R1: After reset, `busy`, `done`, `overflow` and `product` are all 0.
- R2: A `start` sampled high while `busy` is low is accepted at that clock edge. `busy` is high from the next cycle. `done` is high for exactly one cycle, OP_W edges after the accepting edge, and `busy` is low in that same cycle.
- R3: When `done` is high, `product` equals `op_a * op_b` modulo 2^RES_W, using the operand values sampled at the accepting edge (for example 89 times 13 gives 1157).
- R4: The corner operands give exact results: a zero in either operand gives 0, and all-ones times all-ones gives (2^OP_W - 1)^2.
- R5: While `busy` is high, `start` and any change on `op_a` or `op_b` are ignored. The result and the timing of `done` are those of the operation already running.
- R6: While `busy` is low and no start is accepted, `product` and `overflow` hold their values.
- R7: `overflow` is sticky during an operation. When `done` is high, `overflow` is 1 exactly when the true product is 2^RES_W or more, that is, when a 1 was shifted out of the top of the accumulator or the adder carried out of bit RES_W-1.
- R8: An accepted start clears the accumulator and `overflow` at the accepting edge, so a result never depends on earlier operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe; acts only while idle |
| op_a | input | OP_W | Multiplicand, captured in parallel at start |
| op_b | input | OP_W | Multiplier, used serially MSB first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| product | output | RES_W | Accumulated product |
| overflow | output | 1 | Sticky flag: high product bits were lost |

## Verification
Every result of this block is due exactly OP_W rising edges after the edge that accepted `start`; `busy` is due one edge after that edge. The driver records the cycle number at the moment it raises `start` and pushes the expected product, overflow value and due cycle into a queue. The monitor samples on falling edges. When it sees `done`, it pops the oldest entry and checks that the current cycle is the recorded one plus OP_W plus one. A second instance with a narrow result register runs the same stimulus, so truncation and the overflow flag are checked against the same due cycle.

// File: rtl/serial_mult_pkg.sv
package serial_mult_pkg;

    // Controller phase: waiting for a start, or stepping through the bits.
    typedef enum logic [0:0] {
        SM_IDLE = 1'b0,
        SM_RUN  = 1'b1
    } sm_phase_e;

    // Per-cycle control word from the sequencer to the datapath.
    typedef struct packed {
        logic load;   // capture operands, clear accumulator and flag
        logic step;   // one shift-add step this cycle
        logic last;   // this step is the final one
    } sm_ctrl_t;

    // Width of a counter that must reach the value n.
    function automatic int unsigned count_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sm_sequencer.sv
module sm_sequencer
    import serial_mult_pkg::*;
#(
    parameter int unsigned OP_W = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output sm_ctrl_t ctrl,
    output logic     busy,
    output logic     done
);
    localparam int unsigned CNT_W = count_bits(OP_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(OP_W - 1);

    sm_phase_e        phase_q;
    logic [CNT_W-1:0] step_q;

    always_comb begin
        ctrl.load = start && (phase_q == SM_IDLE);
        ctrl.step = (phase_q == SM_RUN);
        ctrl.last = ctrl.step && (step_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= SM_IDLE;
            step_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= ctrl.last;
            if (ctrl.load) begin
                phase_q <= SM_RUN;
                step_q  <= '0;
            end else if (ctrl.step) begin
                step_q <= step_q + 1'b1;
                if (ctrl.last) begin
                    phase_q <= SM_IDLE;
                end
            end
        end
    end

    assign busy = (phase_q == SM_RUN);

endmodule

// File: rtl/sm_serial_operand.sv
module sm_serial_operand #(
    parameter int unsigned OP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [OP_W-1:0] din,
    output logic            tap
);
    logic [OP_W-1:0] sr_q;

    // Shift toward the MSB each step; the bit in use is always the top one.
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= din;
        end else if (step) begin
            sr_q <= {sr_q[OP_W-2:0], 1'b0};
        end
    end

    assign tap = sr_q[OP_W-1];

endmodule

// File: rtl/sm_accumulator.sv
module sm_accumulator #(
    parameter int unsigned OP_W  = 8,
    parameter int unsigned RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             add_en,
    input  logic [OP_W-1:0]  addend,
    output logic [RES_W-1:0] acc,
    output logic             ovf
);
    localparam int unsigned EXT_W = RES_W + 1;

    logic [RES_W-1:0] shifted;
    logic             lost_bit;
    logic [EXT_W-1:0] addend_ext;
    logic [EXT_W-1:0] sum;
    logic [RES_W-1:0] acc_d;
    logic             ovf_d;

    always_comb begin
        shifted    = {acc[RES_W-2:0], 1'b0};
        lost_bit   = acc[RES_W-1];
        addend_ext = EXT_W'(addend);
        sum        = {1'b0, shifted} + addend_ext;
        // Adder enable: the sum is only taken when the serial bit is 1.
        acc_d      = add_en ? sum[RES_W-1:0] : shifted;
        ovf_d      = ovf | lost_bit | (add_en & sum[RES_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (load) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (step) begin
            acc <= acc_d;
            ovf <= ovf_d;
        end
    end

endmodule

// File: rtl/serial_mult.sv
module serial_mult
    import serial_mult_pkg::*;
#(
    parameter int unsigned OP_W  = 8,
    parameter int unsigned RES_W = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] product,
    output logic             overflow
);
    sm_ctrl_t        ctrl;
    logic            serial_bit;
    logic [OP_W-1:0] mcand_q;

    sm_sequencer #(.OP_W(OP_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl),
        .busy  (busy),
        .done  (done)
    );

    // Parallel operand, held for the whole operation.
    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
        end else if (ctrl.load) begin
            mcand_q <= op_a;
        end
    end

    sm_serial_operand #(.OP_W(OP_W)) u_ser (
        .clk  (clk),
        .rst  (rst),
        .load (ctrl.load),
        .step (ctrl.step),
        .din  (op_b),
        .tap  (serial_bit)
    );

    sm_accumulator #(.OP_W(OP_W), .RES_W(RES_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .load   (ctrl.load),
        .step   (ctrl.step),
        .add_en (ctrl.step & serial_bit),
        .addend (mcand_q),
        .acc    (product),
        .ovf    (overflow)
    );

endmodule

// File: rtl/serial_mult_chk.sv
module serial_mult_chk
    import serial_mult_pkg::*;
#(
    parameter int unsigned OP_W  = 8,
    parameter int unsigned RES_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] product,
    input logic             overflow
);
    localparam int unsigned LEN_W = count_bits(OP_W + 1);

    logic [LEN_W-1:0] run_len;

    // Counts the busy cycles since the accepted start.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (start && !busy) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));                               // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                     // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                     // R2
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_len == LEN_W'(OP_W)));                                 // R2
    AST_BUSY_ONLY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));                                       // R5
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(product) && $stable(overflow)));      // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (busy && overflow) |=> overflow);                                    // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (!overflow && product == '0));                  // R8

endmodule

bind serial_mult serial_mult_chk #(.OP_W(OP_W), .RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .product  (product),
    .overflow (overflow)
);

// File: tb/serial_mult_test.sv
module serial_mult_test;
    localparam int unsigned N     = 8;
    localparam int unsigned RW    = 2 * N;
    localparam int unsigned NW    = 10;

    typedef struct {
        logic [31:0] prod;
        logic        ovf;
        int          due;
        string       req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [N-1:0]  op_a = '0;
    logic [N-1:0]  op_b = '0;
    logic          busy, done, overflow;
    logic [RW-1:0] product;
    logic          n_busy, n_done, n_overflow;
    logic [NW-1:0] n_product;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    exp_t q_full[$];
    exp_t q_narrow[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_mult #(.OP_W(N), .RES_W(RW)) uut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .product(product), .overflow(overflow)
    );

    serial_mult #(.OP_W(N), .RES_W(NW)) uut_narrow (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(n_busy), .done(n_done), .product(n_product), .overflow(n_overflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Driver: starts one operation and pushes the expected items.
    task automatic launch(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
        exp_t e;
        logic [31:0] full;
        full  = 32'(a) * 32'(b);
        start = 1'b1;
        op_a  = a;
        op_b  = b;
        e.due = cyc + 1 + N;
        e.req = req;
        e.prod = full;
        e.ovf  = 1'b0;
        q_full.push_back(e);
        e.prod = full % (32'd1 << NW);
        e.ovf  = (full >= (32'd1 << NW));
        q_narrow.push_back(e);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
    endtask

    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
        while (busy) @(negedge clk);
        launch(a, b, req);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops and compares whenever a result is flagged.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                if (q_full.size() == 0) begin
                    check(1'b0, "R2", "unexpected done", 1, 0);
                end else begin
                    e = q_full.pop_front();
                    check(32'(product) == e.prod, e.req, "product", 32'(product), e.prod);
                    check(overflow == e.ovf, "R7", "overflow", 32'(overflow), 32'(e.ovf));
                    check(cyc == e.due, "R2", "done cycle", cyc, e.due);
                    check(!busy, "R2", "busy with done", 32'(busy), 0);
                end
            end
            if (!rst && n_done) begin
                if (q_narrow.size() == 0) begin
                    check(1'b0, "R2", "unexpected narrow done", 1, 0);
                end else begin
                    e = q_narrow.pop_front();
                    check(32'(n_product) == e.prod, e.req, "narrow product", 32'(n_product), e.prod);
                    check(n_overflow == e.ovf, "R7", "narrow overflow", 32'(n_overflow), 32'(e.ovf));
                    check(cyc == e.due, "R2", "narrow done cycle", cyc, e.due);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [RW-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        check(product == '0, "R1", "product after reset", 32'(product), 0);
        check(!overflow, "R1", "overflow after reset", 32'(overflow), 0);

        run_op(8'd89, 8'd13, "R3");
        // R6: result holds while idle
        held = product;
        repeat (6) @(negedge clk);
        check(product == held, "R6", "product held", 32'(product), 32'(held));
        check(product == 16'd1157, "R6", "held value", 32'(product), 1157);
        check(!busy && !done, "R6", "idle state", {busy, done}, 0);

        run_op(8'd0, 8'd200, "R4");
        run_op(8'd200, 8'd0, "R4");
        run_op(8'd255, 8'd255, "R4");
        run_op(8'd1, 8'd1, "R4");
        run_op(8'd255, 8'd1, "R4");
        run_op(8'd1, 8'd255, "R4");

        // R5: a start with new operands in mid-operation is ignored
        launch(8'd100, 8'd77, "R5");
        repeat (2) @(negedge clk);
        start = 1'b1;
        op_a  = 8'd5;
        op_b  = 8'd7;
        @(negedge clk);
        start = 1'b0;
        op_a  = 8'd9;
        check(busy == 1'b1, "R5", "still busy", 32'(busy), 1);
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!busy, "R5", "idle after ignored start", 32'(busy), 0);

        // R8: overflowing narrow operation, then a small one
        run_op(8'd255, 8'd255, "R8");
        run_op(8'd3, 8'd5, "R8");
        check(n_product == 10'd15 && !n_overflow, "R8", "narrow cleared",
              {n_overflow, 22'd0, n_product[9:0]} , 15);

        for (int i = 0; i < 30; i++) begin
            run_op(N'($urandom), N'($urandom), "R3");
        end

        repeat (3) @(negedge clk);
        check(q_full.size() == 0 && q_narrow.size() == 0, "R2", "queues drained",
              q_full.size() + q_narrow.size(), 0);
        finish_run();
    end

endmodule